// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block turns the interrupt sources of a UART into one prioritized identification byte and a single interrupt request line. It holds the 4-bit interrupt-enable register, the character-timeout pending flag and the transmitter-empty pending flag. Every cycle it compares the enabled sources and reports the one with the highest priority. The FIFOs, the serializer, the timeout timer and the baud generator stay outside. Those neighbours report events and levels to this block: a finished transmission, a timer expiry, the receive FIFO count, the line error bits and the modem status change bits.

The two pending flags are small state machines with the states `PEND_IDLE` and `PEND_ARMED`. The *arm* transition goes from `PEND_IDLE` to `PEND_ARMED` on a set event. The *clear* transition goes from `PEND_ARMED` to `PEND_IDLE` on a clear event. With no event, or when a set and a clear cancel out, each state *holds*. When a set and a clear arrive in the same cycle, a parameter chooses the winner:
- The transmitter-empty flag lets the set win.
- The timeout flag lets the clear win.

A host read of the identification byte is signalled with `iir_rd`. If the byte shows the transmitter-empty code at that moment, the read acknowledges that source.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the stored enables are 0, both pending flags are in `PEND_IDLE`, the low nibble of `iir_value` is 0x1 and `irq` is low.
- R2: Among the enabled sources the code shown in `iir_value[3:0]` is that of the highest priority. The order is line status (0x6), then character timeout (0xC), then receive data (0x4), then transmitter empty (0x2), then modem status (0x0). With nothing pending the code is 0x1.
- R3: The line status source is active when enable bit 2 is set and any of `lsr_bits[4:1]` is set (overrun, parity, framing, break). `lsr_bits[7:5]` have no effect on the output.
- R4: A `tmo_set` pulse arms the timeout flag only while `fifo_on` is high and `rx_level` is nonzero. A `tmo_clr` pulse clears the flag, and a clear in the same cycle as a set wins. The flag is reported only while enable bit 0 is set.
- R5: The receive data source needs enable bit 0 and `lsr_bits[0]`. While `fifo_on` is high it also needs `rx_level` at or above the trigger level. `trig_sel` values 0, 1, 2 and 3 select levels 1, 4, 8 and 14.
- R6: The transmitter-empty flag is armed by a `tx_done` pulse, or by an enable write while `thr_empty` is high. A `thr_wr` pulse clears it, and a set in the same cycle wins. It is reported only while enable bit 1 is set.
- R7: When `iir_rd` is high while the code is 0x2, the transmitter-empty flag clears and the next cycle shows the re-evaluated code. A read while any other code shows leaves the flag unchanged. A read in the same cycle as a set event leaves the flag armed.
- R8: The modem status source is active when enable bit 3 is set and any bit of `msr_delta` is set. Its code 0x0 still raises `irq`.
- R9: `iir_value[7:6]` both equal `fifo_on` and `iir_value[5:4]` are 0, whatever the low nibble holds.
- R10: `irq` is high exactly when `iir_value[3:0]` differs from 0x1. It follows input changes in the same cycle, without a register stage.
- R11: An enable write stores only `ier_wdata[3:0]`. `ier_value` reads back those bits with its upper nibble 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_value | output | 8 | Stored enables, upper nibble zero |
| lsr_bits | input | 8 | Line status: bit0 data ready, bits 4:1 errors and break |
| fifo_on | input | 1 | FIFO mode active |
| trig_sel | input | 2 | Receive trigger level select |
| rx_level | input | CNT_W (5) | Receive FIFO fill count |
| tmo_set | input | 1 | Character timeout expiry pulse |
| tmo_clr | input | 1 | Timeout acknowledge pulse (receive read or FIFO flush) |
| thr_empty | input | 1 | Transmit holding register empty level |
| tx_done | input | 1 | Transmission finished with holding register empty |
| thr_wr | input | 1 | Host wrote the transmit holding register |
| msr_delta | input | 4 | Modem status change bits |
| iir_rd | input | 1 | Host read strobe of the identification byte |
| iir_value | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default FIFO depth of 16, which gives a 5-bit count. The four default trigger levels 1, 4, 8 and 14 all lie within that count range. This lets the bench test each level one count below and exactly at the threshold, including the 13/14 edge at the top of the FIFO. The bench also drives same-cycle collisions on both pending flags to show the two different arbitration variants. It places the identification read in the same cycle as a new transmit event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_THR     = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_e;

    typedef enum logic {
        PEND_IDLE  = 1'b0,
        PEND_ARMED = 1'b1
    } pend_state_e;

    // Source slots, index 0 is the highest priority
    localparam int SRC_LINE    = 0;
    localparam int SRC_TIMEOUT = 1;
    localparam int SRC_RXDATA  = 2;
    localparam int SRC_THR     = 3;
    localparam int SRC_MODEM   = 4;
    localparam int N_SRC       = 5;

    function automatic iid_e src_code(input int idx);
        iid_e c;
        case (idx)
            SRC_LINE:    c = IID_LINE;
            SRC_TIMEOUT: c = IID_TIMEOUT;
            SRC_RXDATA:  c = IID_RXDATA;
            SRC_THR:     c = IID_THR;
            SRC_MODEM:   c = IID_MODEM;
            default:     c = IID_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_pend_fsm.sv
module uart_irq_pend_fsm
    import uart_irq_pkg::*;
#(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    pend_state_e state_q, state_d;
    logic        do_arm, do_clear;

    // Arbitration variant picked by parameter
    generate
        if (SET_WINS) begin : g_set_wins
            assign do_arm   = set_i;
            assign do_clear = clr_i & ~set_i;
        end else begin : g_clr_wins
            assign do_arm   = set_i & ~clr_i;
            assign do_clear = clr_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PEND_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE:  if (do_arm)   state_d = PEND_ARMED;
            PEND_ARMED: if (do_clear) state_d = PEND_IDLE;
            default:    state_d = PEND_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == PEND_ARMED);
    end

endmodule

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
    parameter int CNT_W  = 5,
    parameter int TRIG_A = 1,
    parameter int TRIG_B = 4,
    parameter int TRIG_C = 8,
    parameter int TRIG_D = 14
) (
    input  logic             fifo_on,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             data_ready,
    output logic             rx_ok
);

    localparam logic [CNT_W-1:0] LVL_A = CNT_W'(TRIG_A);
    localparam logic [CNT_W-1:0] LVL_B = CNT_W'(TRIG_B);
    localparam logic [CNT_W-1:0] LVL_C = CNT_W'(TRIG_C);
    localparam logic [CNT_W-1:0] LVL_D = CNT_W'(TRIG_D);

    logic [CNT_W-1:0] level;

    always_comb begin
        unique case (trig_sel)
            2'd0: level = LVL_A;
            2'd1: level = LVL_B;
            2'd2: level = LVL_C;
            2'd3: level = LVL_D;
            default: level = LVL_A;
        endcase
    end

    always_comb begin
        rx_ok = data_ready & (~fifo_on | (rx_level >= level));
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [N_SRC-1:0] req,
    output iid_e             code
);

    // Walk from lowest priority up so the highest active source is left
    always_comb begin
        code = IID_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) code = src_code(i);
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TRIG_A     = 1,
    parameter int TRIG_B     = 4,
    parameter int TRIG_C     = 8,
    parameter int TRIG_D     = 14,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    output logic [7:0]       ier_value,
    input  logic [7:0]       lsr_bits,
    input  logic             fifo_on,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             tmo_set,
    input  logic             tmo_clr,
    input  logic             thr_empty,
    input  logic             tx_done,
    input  logic             thr_wr,
    input  logic [3:0]       msr_delta,
    input  logic             iir_rd,
    output logic [7:0]       iir_value,
    output logic             irq
);

    localparam int IER_W = 4;

    logic [IER_W-1:0] ier_q;
    logic             thr_pend, tmo_pend;
    logic             thr_arm, thr_drop, tmo_arm;
    logic             rx_ok;
    logic [N_SRC-1:0] req;
    iid_e             code;
    logic             unused_hi;

    assign unused_hi = ^{ier_wdata[7:IER_W], lsr_bits[7:5]};

    always_ff @(posedge clk) begin
        if (!rst_n)      ier_q <= '0;
        else if (ier_wr) ier_q <= ier_wdata[IER_W-1:0];
    end

    assign ier_value = {{(8-IER_W){1'b0}}, ier_q};

    // Transmitter-empty flag: set events beat clears
    assign thr_arm  = tx_done | (ier_wr & thr_empty);
    assign thr_drop = thr_wr | (iir_rd & (code == IID_THR));

    uart_irq_pend_fsm #(.SET_WINS(1'b1)) u_thr_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (thr_arm),
        .clr_i  (thr_drop),
        .pend_o (thr_pend)
    );

    // Character timeout flag: acknowledge beats a new expiry
    assign tmo_arm = tmo_set & fifo_on & (rx_level != '0);

    uart_irq_pend_fsm #(.SET_WINS(1'b0)) u_tmo_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tmo_arm),
        .clr_i  (tmo_clr),
        .pend_o (tmo_pend)
    );

    uart_irq_trig #(
        .CNT_W  (CNT_W),
        .TRIG_A (TRIG_A),
        .TRIG_B (TRIG_B),
        .TRIG_C (TRIG_C),
        .TRIG_D (TRIG_D)
    ) u_trig (
        .fifo_on    (fifo_on),
        .trig_sel   (trig_sel),
        .rx_level   (rx_level),
        .data_ready (lsr_bits[0]),
        .rx_ok      (rx_ok)
    );

    always_comb begin
        req              = '0;
        req[SRC_LINE]    = ier_q[2] & (|lsr_bits[4:1]);
        req[SRC_TIMEOUT] = ier_q[0] & tmo_pend;
        req[SRC_RXDATA]  = ier_q[0] & rx_ok;
        req[SRC_THR]     = ier_q[1] & thr_pend;
        req[SRC_MODEM]   = ier_q[3] & (|msr_delta);
    end

    uart_irq_prio u_prio (
        .req  (req),
        .code (code)
    );

    assign iir_value = {fifo_on, fifo_on, 2'b00, code};
    assign irq       = (code != IID_NONE);

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ier_wr,
    input logic [7:0]       ier_wdata,
    input logic [7:0]       ier_value,
    input logic [7:0]       lsr_bits,
    input logic             fifo_on,
    input logic [CNT_W-1:0] rx_level,
    input logic             thr_empty,
    input logic             tx_done,
    input logic [3:0]       msr_delta,
    input logic             iir_rd,
    input logic [7:0]       iir_value,
    input logic             irq
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (iir_value[3:0] == 4'h1 && ier_value == 8'h00));

    // R3
    line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_value[2] && (|lsr_bits[4:1])) |-> iir_value[3:0] == 4'h6);

    // R4
    tmo_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_value[0] |-> (iir_value[3:0] != 4'hC && iir_value[3:0] != 4'h4));

    // R7
    thr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_value[3:0] == 4'h2 && !tx_done && !(ier_wr && thr_empty))
        |=> iir_value[3:0] != 4'h2);

    // R8
    modem_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_value[3] && (|msr_delta)) |-> irq);

    // R9
    fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir_value[5:4] == 2'b00 && iir_value[7] == fifo_on && iir_value[6] == fifo_on);

    // R10
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_value[3:0] == 4'h1) |-> !irq);

    // R11
    ier_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> ier_value == {4'h0, $past(ier_wdata[3:0])});

    logic unused_chk;
    assign unused_chk = ^rx_level;

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_wr    (ier_wr),
    .ier_wdata (ier_wdata),
    .ier_value (ier_value),
    .lsr_bits  (lsr_bits),
    .fifo_on   (fifo_on),
    .rx_level  (rx_level),
    .thr_empty (thr_empty),
    .tx_done   (tx_done),
    .msr_delta (msr_delta),
    .iir_rd    (iir_rd),
    .iir_value (iir_value),
    .irq       (irq)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ier_wr = 1'b0;
    logic [7:0]       ier_wdata = 8'h00;
    logic [7:0]       ier_value;
    logic [7:0]       lsr_bits = 8'h00;
    logic             fifo_on = 1'b0;
    logic [1:0]       trig_sel = 2'd0;
    logic [CNT_W-1:0] rx_level = '0;
    logic             tmo_set = 1'b0;
    logic             tmo_clr = 1'b0;
    logic             thr_empty = 1'b0;
    logic             tx_done = 1'b0;
    logic             thr_wr = 1'b0;
    logic [3:0]       msr_delta = 4'h0;
    logic             iir_rd = 1'b0;
    logic [7:0]       iir_value;
    logic             irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       chk_ev;

    always #2 clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ier_value(ier_value), .lsr_bits(lsr_bits), .fifo_on(fifo_on),
        .trig_sel(trig_sel), .rx_level(rx_level), .tmo_set(tmo_set),
        .tmo_clr(tmo_clr), .thr_empty(thr_empty), .tx_done(tx_done),
        .thr_wr(thr_wr), .msr_delta(msr_delta), .iir_rd(iir_rd),
        .iir_value(iir_value), .irq(irq)
    );

    // Monitor: pops one expected item per request, 1 ns after it is pushed
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (exp_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                logic       e_irq;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                e_irq = (e[3:0] != 4'h1);
                n_checks++;
                if (iir_value !== e || irq !== e_irq) begin
                    n_errors++;
                    $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                             t, iir_value, irq, e, e_irq);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver side of the scoreboard: queue one expectation, then advance a cycle
    task automatic expect_iir(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        ->chk_ev;
        tick();
    endtask

    task automatic check_ier(input logic [7:0] e, input string t);
        n_checks++;
        if (ier_value !== e) begin
            n_errors++;
            $display("FAIL %s: ier=%02h expected %02h", t, ier_value, e);
        end
    endtask

    task automatic write_ier(input logic [7:0] v);
        ier_wdata = v;
        ier_wr = 1'b1;
        tick();
        ier_wr = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        expect_iir(8'h01, "R1 reset code");
        check_ier(8'h00, "R1 reset enables");

        write_ier(8'hFF);
        check_ier(8'h0F, "R11 upper bits dropped");
        expect_iir(8'h01, "R10 nothing pending");

        // line status
        lsr_bits = 8'h02; expect_iir(8'h06, "R3 overrun");
        lsr_bits = 8'h08; expect_iir(8'h06, "R3 framing");
        lsr_bits = 8'h20; expect_iir(8'h01, "R3 bit5 ignored");
        lsr_bits = 8'h80; expect_iir(8'h01, "R3 bit7 ignored");
        lsr_bits = 8'h01; expect_iir(8'h04, "R5 data ready no fifo");
        lsr_bits = 8'h11; expect_iir(8'h06, "R2 line over rx data");
        lsr_bits = 8'h00; msr_delta = 4'h2;
        expect_iir(8'h00, "R8 modem code raises irq");
        lsr_bits = 8'h01; expect_iir(8'h04, "R2 rx data over modem");
        msr_delta = 4'h0;
        write_ier(8'hFB);
        check_ier(8'h0B, "R11 readback");
        lsr_bits = 8'h11; expect_iir(8'h04, "R3 line masked");

        // trigger levels
        lsr_bits = 8'h01; fifo_on = 1'b1;
        trig_sel = 2'd1; rx_level = 5'd3;  expect_iir(8'hC1, "R5 level 3 below 4");
        rx_level = 5'd4;                   expect_iir(8'hC4, "R5 level 4 at 4");
        trig_sel = 2'd3; rx_level = 5'd13; expect_iir(8'hC1, "R5 level 13 below 14");
        rx_level = 5'd14;                  expect_iir(8'hC4, "R5 level 14 at 14");
        trig_sel = 2'd2; rx_level = 5'd7;  expect_iir(8'hC1, "R5 level 7 below 8");
        rx_level = 5'd8;                   expect_iir(8'hC4, "R5 level 8 at 8");
        trig_sel = 2'd0; rx_level = 5'd1;  expect_iir(8'hC4, "R5 level 1 at 1");
        lsr_bits = 8'h00; rx_level = 5'd14; expect_iir(8'hC1, "R5 needs data ready");

        // timeout
        lsr_bits = 8'h01; trig_sel = 2'd3; rx_level = 5'd2;
        expect_iir(8'hC1, "R9 fifo bits with none");
        tmo_set = 1'b1; tick(); tmo_set = 1'b0;
        expect_iir(8'hCC, "R4 timeout armed");
        write_ier(8'h0A); expect_iir(8'hC1, "R4 masked by rx enable");
        write_ier(8'h0B); expect_iir(8'hCC, "R4 unmasked again");
        rx_level = 5'd14; expect_iir(8'hCC, "R2 timeout over rx data");
        write_ier(8'h0F); lsr_bits = 8'h03;
        expect_iir(8'hC6, "R2 line over timeout");
        lsr_bits = 8'h01;
        tmo_clr = 1'b1; tick(); tmo_clr = 1'b0;
        expect_iir(8'hC4, "R4 cleared shows rx data");
        rx_level = 5'd2; expect_iir(8'hC1, "R4 cleared");
        rx_level = 5'd0;
        tmo_set = 1'b1; tick(); tmo_set = 1'b0;
        rx_level = 5'd2; expect_iir(8'hC1, "R4 set ignored at level 0");
        tmo_set = 1'b1; tmo_clr = 1'b1; tick(); tmo_set = 1'b0; tmo_clr = 1'b0;
        expect_iir(8'hC1, "R4 clear wins");
        fifo_on = 1'b0; lsr_bits = 8'h00;
        tmo_set = 1'b1; tick(); tmo_set = 1'b0;
        expect_iir(8'h01, "R9 fifo bits off");
        fifo_on = 1'b1; lsr_bits = 8'h01;
        expect_iir(8'hC1, "R4 set ignored without fifo");

        // transmitter empty
        fifo_on = 1'b0; lsr_bits = 8'h00; rx_level = 5'd0;
        write_ier(8'h02); expect_iir(8'h01, "R6 no arm while full");
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        expect_iir(8'h02, "R6 armed by tx_done");
        iir_rd = 1'b1; expect_iir(8'h02, "R7 code during read");
        iir_rd = 1'b0; expect_iir(8'h01, "R7 acknowledged by read");
        thr_empty = 1'b1; write_ier(8'h02); thr_empty = 1'b0;
        expect_iir(8'h02, "R6 rearmed by enable write");
        thr_wr = 1'b1; tick(); thr_wr = 1'b0;
        expect_iir(8'h01, "R6 cleared by holding write");
        write_ier(8'h03);
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        lsr_bits = 8'h01; expect_iir(8'h04, "R2 rx data over thr");
        iir_rd = 1'b1; tick(); iir_rd = 1'b0;
        lsr_bits = 8'h00; expect_iir(8'h02, "R7 other code read keeps flag");
        iir_rd = 1'b1; tx_done = 1'b1; tick(); iir_rd = 1'b0; tx_done = 1'b0;
        expect_iir(8'h02, "R7 set wins over read");
        thr_wr = 1'b1; tx_done = 1'b1; tick(); thr_wr = 1'b0; tx_done = 1'b0;
        expect_iir(8'h02, "R6 set wins over holding write");
        write_ier(8'h0A); msr_delta = 4'h1;
        expect_iir(8'h02, "R2 thr over modem");
        thr_wr = 1'b1; tick(); thr_wr = 1'b0;
        expect_iir(8'h00, "R8 modem after thr cleared");
        msr_delta = 4'h0; expect_iir(8'h01, "R8 no delta");

        // reset in mid-run
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        expect_iir(8'h02, "R6 armed before reset");
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        expect_iir(8'h01, "R1 reset clears flags");
        check_ier(8'h00, "R1 reset clears enables");
        write_ier(8'h02);
        expect_iir(8'h01, "R1 thr flag stayed idle");

        #5;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule